// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block holds the digital search logic of a 10-bit charge-redistribution converter. The capacitor array, the comparator and its offset cancellation sit outside. On a start request the block opens one sample cycle, then runs a binary search that settles one bit per clock, from the most significant bit down to the least. On every bit cycle it drives a trial code to the capacitor array and reads back a single comparator bit.

The comparator polarity is active-high for "input below trial level". A low comparator result keeps the bit under test and a high result clears it. When the last bit has been decided, the block writes the plain binary result to its output register and raises a data-enable flag for one clock. The expected conversion clock is 2.5 MHz. The logic itself does not depend on the clock frequency.

Top module: `sar_seq`

## Requirements
- R1: After reset the block is idle: `busy` = 0, `sampleEn` = 0, `dataEn` = 0, `trialCode` = 0 and `dataOut` = 0.
- R2: `startReq` is sampled high on a clock edge while the block is idle. The next cycle is the sample cycle, with `sampleEn` = 1, `busy` = 1 and `trialCode` = 0. The cycle after that is the first bit cycle, with `trialCode` = 10'b10_0000_0000.
- R3: If `cmpHigh` is 0 on the edge that ends a bit cycle, the bit under test stays 1.
- R4: If `cmpHigh` is 1 on the edge that ends a bit cycle, the bit under test is cleared to 0.
- R5: Once a bit is decided it does not change for the rest of the conversion. The next bit cycle tests the next lower bit, which is set to 1 with all bits below it at 0. There are exactly 10 bit cycles, ending with bit 0.
- R6: In the cycle after the edge that decides bit 0, `dataEn` is 1 for exactly one clock and `busy` is 0. In that cycle `dataOut` carries the decided code as straight binary. This cycle is 11 cycles after the sample cycle began.
- R7: `dataOut` holds its value in every cycle where `dataEn` is 0.
- R8: A `startReq` seen while `busy` is 1 is ignored. The running search, its result and its timing are unchanged.
- R9: While the block is idle, `trialCode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Request to begin a conversion |
| cmpHigh | input | 1 | Comparator result, 1 when the input is below the trial level |
| trialCode | output | 10 | Code driven to the capacitor array |
| sampleEn | output | 1 | High during the sample cycle |
| busy | output | 1 | High during the sample and bit cycles |
| dataOut | output | 10 | Last completed conversion result |
| dataEn | output | 1 | One-cycle flag marking a new result |

## Verification
The assertions assume that `cmpHigh` is a settled function of the present trial code by the end of each bit cycle. The bench meets this by driving `cmpHigh` combinationally, as the input level being below `trialCode`. Under that model every input from 0 to 1023 must come back unchanged, and the trial code of each bit cycle can be predicted from the input alone. The bench drives `startReq` only on falling edges, so each request falls clearly inside one cycle. The interruption test places it in the middle of the search.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // Strobes issued by the sequencer to the datapath in a given cycle.
  typedef struct packed {
    logic loadMsb;   // end of sample cycle: present the first trial
    logic decide;    // end of a bit cycle: resolve the bit under test
    logic lastBit;   // the bit being resolved is bit 0
  } sarCtl_t;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int W = 10
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  output sarCtl_t ctl,
  output logic    sampleEn,
  output logic    busy
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_CONV} state_t;

  state_t        state;
  logic [IW-1:0] bitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE:   if (startReq) state <= ST_SAMPLE;
        ST_SAMPLE: begin
          state  <= ST_CONV;
          bitIdx <= TOP_IDX;
        end
        ST_CONV: begin
          if (bitIdx == '0) state <= ST_IDLE;
          else              bitIdx <= bitIdx - 1'b1;
        end
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.loadMsb = (state == ST_SAMPLE);
    ctl.decide  = (state == ST_CONV);
    ctl.lastBit = (state == ST_CONV) && (bitIdx == '0);
  end

  assign sampleEn = (state == ST_SAMPLE);
  assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  sarCtl_t      ctl,
  input  logic         cmpHigh,
  output logic [W-1:0] trialCode,
  output logic [W-1:0] dataOut,
  output logic         dataEn
);
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] testMask;   // one-hot marker of the bit under test
  logic [W-1:0] decided;

  // Clear the tested bit on a high comparator result, then arm the next lower bit.
  always_comb begin
    decided = trialCode & ~(cmpHigh ? testMask : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trialCode <= '0;
      testMask  <= '0;
      dataOut   <= '0;
      dataEn    <= 1'b0;
    end else begin
      dataEn <= 1'b0;
      if (ctl.loadMsb) begin
        trialCode <= MSB_ONLY;
        testMask  <= MSB_ONLY;
      end else if (ctl.decide) begin
        if (ctl.lastBit) begin
          dataOut   <= decided;
          dataEn    <= 1'b1;
          trialCode <= '0;
          testMask  <= '0;
        end else begin
          trialCode <= decided | (testMask >> 1);
          testMask  <= testMask >> 1;
        end
      end
    end
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         cmpHigh,
  output logic [W-1:0] trialCode,
  output logic         sampleEn,
  output logic         busy,
  output logic [W-1:0] dataOut,
  output logic         dataEn
);
  sarCtl_t ctl;

  sar_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .ctl      (ctl),
    .sampleEn (sampleEn),
    .busy     (busy)
  );

  sar_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .cmpHigh   (cmpHigh),
    .trialCode (trialCode),
    .dataOut   (dataOut),
    .dataEn    (dataEn)
  );
endmodule

// File: rtl/sar_seq_checker.sv
module sar_seq_checker #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] trialCode,
  input logic         sampleEn,
  input logic         busy,
  input logic [W-1:0] dataOut,
  input logic         dataEn
);
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

  a_r2_first_trial: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |=> (trialCode == MSB_ONLY) && !sampleEn && busy);

  a_r2_sample_zero: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |-> (trialCode == '0) && busy);

  a_r5_bit_armed: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !sampleEn) |-> (trialCode != '0));

  a_r6_one_pulse: assert property (@(posedge clk) disable iff (!rstN)
    dataEn |=> !dataEn);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    dataEn |-> !busy && $past(busy));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !dataEn |-> $stable(dataOut));

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |-> !$past(busy));

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (trialCode == '0));
endmodule

bind sar_seq sar_seq_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .trialCode (trialCode),
  .sampleEn  (sampleEn),
  .busy      (busy),
  .dataOut   (dataOut),
  .dataEn    (dataEn)
);

// File: tb/sim_sar_seq.sv
`timescale 1ns/1ps
module sim_sar_seq;
  localparam int W = 10;
  localparam int NV = 12;
  localparam logic [W-1:0] VEC [NV] = '{
    10'd0, 10'd1023, 10'd512, 10'd511, 10'd341, 10'd682,
    10'd1, 10'd1022, 10'd256, 10'd767, 10'd100, 10'd900
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startReq = 1'b0;
  logic         cmpHigh;
  logic [W-1:0] trialCode;
  logic         sampleEn;
  logic         busy;
  logic [W-1:0] dataOut;
  logic         dataEn;
  logic [W-1:0] vinLevel = '0;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  // Behavioural comparator: high when the input sits below the trial level.
  always_comb cmpHigh = (vinLevel < trialCode);

  sar_seq #(.W(W)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmpHigh(cmpHigh),
    .trialCode(trialCode), .sampleEn(sampleEn), .busy(busy),
    .dataOut(dataOut), .dataEn(dataEn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One full conversion; optionally a stray start request mid-search (R8).
  task automatic convert(input logic [W-1:0] vin, input bit interrupt);
    vinLevel = vin;
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    check(sampleEn == 1'b1 && busy == 1'b1, "R2 sample cycle", int'(sampleEn), 1);
    check(trialCode == '0, "R2 sample trial", int'(trialCode), 0);
    for (int k = W - 1; k >= 0; k--) begin
      @(negedge clk);
      startReq = 1'b0;
      // Expected trial: input bits above k already decided, bit k armed.
      check(trialCode == ((vin & ~((W'(1) << (k + 1)) - 1'b1)) | (W'(1) << k)),
            "R3 R4 R5 trial code", int'(trialCode),
            int'((vin & ~((W'(1) << (k + 1)) - 1'b1)) | (W'(1) << k)));
      check(dataEn == 1'b0 && busy == 1'b1, "R5 still searching", int'(dataEn), 0);
      if (interrupt && k == 5) startReq = 1'b1;
    end
    @(negedge clk) startReq = 1'b0;
    check(dataEn == 1'b1 && busy == 1'b0, "R6 completion flag", int'(dataEn), 1);
    check(dataOut == vin, "R6 result", int'(dataOut), int'(vin));
    check(trialCode == '0, "R9 idle trial", int'(trialCode), 0);
    @(negedge clk);
    check(dataEn == 1'b0, "R6 single pulse", int'(dataEn), 0);
    check(dataOut == vin && busy == 1'b0, "R7 R8 hold and no restart", int'(dataOut), int'(vin));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && sampleEn == 0 && dataEn == 0, "R1 reset flags", int'(busy), 0);
    check(trialCode == 0 && dataOut == 0, "R1 reset codes", int'(trialCode), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && trialCode == 0, "R1 idle after reset", int'(busy), 0);

    for (int i = 0; i < NV; i++) convert(VEC[i], 1'b0);

    // R8: start held through a running conversion.
    convert(10'd613, 1'b1);

    // R7: output survives idle time and an input change with no start.
    vinLevel = 10'd5;
    repeat (5) @(negedge clk);
    check(dataOut == 10'd613 && busy == 0, "R7 idle hold", int'(dataOut), 613);

    // R9/R1: reset in mid-conversion returns to idle.
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(busy == 0 && trialCode == 0 && dataOut == 0, "R1 mid-run reset", int'(trialCode), 0);
    rstN = 1'b1;
    convert(10'd77, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule